// File: doc/BRIEF.md
# Locked Pair Backoff Sequencer

This block is a bus-master sequencer that performs an atomic read-modify-write. It issues a memory read and then a memory write to the same address, and it holds a bus lock output active across both cycles. A requester starts a pair by presenting an address, byte enables and write data. When the write finishes, the requester gets a one-clock done pulse together with the data returned by the read.

The system can force the sequencer off the bus at any clock through an active-low backoff input. When backoff is seen during a bus cycle, the sequencer drops that cycle and releases every output it drives, the lock output included. It stays off the bus for as long as backoff is held. While it is off the bus, another agent may snoop it. A snoop that hits a modified line is flagged through a hit input, which comes with the line's address and data.

When backoff is released, the sequencer first writes back any flagged line as a locked cycle. It then replays the dropped cycle from its own saved copy of the request. A read that already completed is never issued again.

Top module: `lkpair_seq`

## Requirements
- R1: While reset is held and on leaving reset, the block is idle: bus_oe=0, bus_dout_oe=0, bus_ads_n=1, bus_lock_n=1, busy=0, done=0.
- R2: A req_valid seen at an edge while idle, with bus_boff_n=1, is accepted. In the next cycle the block drives a read with bus_ads_n=0, bus_lock_n=0, bus_wr=0, bus_oe=1, bus_addr=req_addr and bus_be=req_be. bus_ads_n is low for exactly one cycle per cycle start.
- R3: A read ends at the first edge after its address cycle where bus_rdy_n=0, and bus_din is captured at that edge. The next cycle drives the write: bus_ads_n=0, bus_wr=1, bus_dout=req_wdata, bus_dout_oe=1. bus_lock_n stays 0 from the read's address cycle through the whole write.
- R4: A write ends at the first edge after its address cycle where bus_rdy_n=0. In the next cycle bus_lock_n=1, bus_oe=0, and done=1 for exactly one cycle, with rdata equal to the captured read data. The cycle after that, busy=0.
- R5: bus_boff_n=0 at an edge during an address or wait cycle aborts that cycle, even if bus_rdy_n=0 at the same edge. From the next cycle, bus_oe=0 and bus_dout_oe=0 for as long as bus_boff_n stays 0.
- R6: At the first edge with bus_boff_n=1, if no writeback is pending, the aborted cycle restarts in the next cycle with bus_ads_n=0, bus_lock_n=0 and the original address, byte enables and write data. A write is replayed as a write, never as a repeated read.
- R7: snp_hitm=1 at an edge while the block is floated in backoff (with bus_boff_n=0) records snp_addr and snp_data; the first such hit is kept. After release, a locked writeback runs first: bus_wr=1, bus_lock_n=0, bus_addr=snp_addr, bus_be all ones, bus_dout=snp_data. When it ends on bus_rdy_n=0, the aborted cycle restarts in the next cycle.
- R8: bus_boff_n=0 while idle keeps the bus floated and blocks acceptance: req_valid is ignored (busy stays 0) until bus_boff_n=1.
- R9: req_valid while busy is ignored. The pending pair keeps its saved address and write data.
- R10: A backoff that aborts the writeback cycle leaves it pending. After release, the writeback is issued again before the original locked cycle resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request to start a locked pair |
| req_addr | input | AW | Pair address |
| req_be | input | BEW | Pair byte enables |
| req_wdata | input | DW | Data for the write half |
| busy | output | 1 | A pair is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Data returned by the read half |
| bus_oe | output | 1 | Enable for address, control and lock outputs |
| bus_dout_oe | output | 1 | Enable for the write data bus |
| bus_ads_n | output | 1 | Address strobe, active low |
| bus_lock_n | output | 1 | Bus lock, active low |
| bus_wr | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | AW | Cycle address |
| bus_be | output | BEW | Cycle byte enables |
| bus_dout | output | DW | Write data |
| bus_din | input | DW | Read data from the bus |
| bus_rdy_n | input | 1 | Cycle completion, active low |
| bus_boff_n | input | 1 | Backoff, active low |
| snp_hitm | input | 1 | Snoop hit a modified line |
| snp_addr | input | AW | Address of the modified line |
| snp_data | input | DW | Data of the modified line |

## Verification
Every output decodes the state register, so each response shows up one clock after the edge where its cause was sampled. An accept, a ready, a backoff or a release at edge N is visible from edge N+1. The bench drives inputs and samples outputs on the falling edge. It compares right after the rising edge that should have caused the change, and only then sets up the inputs for the next edge. Wait states come from the stimulus table, so each ready arrives one edge after the count of idle wait cycles the table requests.

// File: rtl/lkpair_pkg.sv
// Shared types for the locked pair sequencer.
package lkpair_pkg;

    // Sequencer states; each bus cycle has an address clock and a wait clock.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_ADS,
        ST_RD_WAIT,
        ST_WR_ADS,
        ST_WR_WAIT,
        ST_WB_ADS,
        ST_WB_WAIT,
        ST_BOFF,
        ST_DONE
    } seq_state_e;

    // Which kind of cycle is (or was) on the bus.
    typedef enum logic [1:0] {
        PH_RD,
        PH_WR,
        PH_WB
    } phase_e;

endpackage

// File: rtl/lkpair_ctrl.sv
// Control sequencer for the locked pair.
// Walks read -> write under lock. On backoff it parks in ST_BOFF and
// remembers which cycle to replay. A snoop hit taken in ST_BOFF queues a
// writeback, which is issued before the replay.
// Assumes: bus_rdy_n is only meaningful in wait clocks; the first snoop hit
// per backoff window is the one kept.
module lkpair_ctrl
    import lkpair_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       boff_n,
    input  logic       rdy_n,
    input  logic       snp_hitm,
    output seq_state_e state_o,
    output logic       accept_o,
    output logic       rd_cap_o,
    output logic       wb_cap_o
);

    seq_state_e st_q, st_d;
    phase_e     resume_q, resume_d;
    logic       wb_pend_q, wb_pend_d;

    // Cycle kind belonging to an active bus state.
    function automatic phase_e phase_of(input seq_state_e s);
        phase_e p;
        case (s)
            ST_RD_ADS, ST_RD_WAIT: p = PH_RD;
            ST_WR_ADS, ST_WR_WAIT: p = PH_WR;
            default:               p = PH_WB;
        endcase
        return p;
    endfunction

    // Address-clock state that starts a cycle of the given kind.
    function automatic seq_state_e ads_of(input phase_e p);
        seq_state_e s;
        case (p)
            PH_RD:   s = ST_RD_ADS;
            PH_WR:   s = ST_WR_ADS;
            default: s = ST_WB_ADS;
        endcase
        return s;
    endfunction

    // Next-state, resume and writeback-pending decisions.
    always_comb begin
        st_d      = st_q;
        resume_d  = resume_q;
        wb_pend_d = wb_pend_q;
        accept_o  = 1'b0;
        rd_cap_o  = 1'b0;
        wb_cap_o  = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req_valid && boff_n) begin
                    st_d     = ST_RD_ADS;
                    accept_o = 1'b1;
                end
            end
            ST_RD_ADS, ST_WR_ADS, ST_WB_ADS: begin
                if (!boff_n) begin
                    st_d = ST_BOFF;
                    if (st_q != ST_WB_ADS) begin
                        resume_d = phase_of(st_q);
                    end
                end else if (st_q == ST_RD_ADS) begin
                    st_d = ST_RD_WAIT;
                end else if (st_q == ST_WR_ADS) begin
                    st_d = ST_WR_WAIT;
                end else begin
                    st_d = ST_WB_WAIT;
                end
            end
            ST_RD_WAIT, ST_WR_WAIT, ST_WB_WAIT: begin
                if (!boff_n) begin
                    st_d = ST_BOFF;
                    if (st_q != ST_WB_WAIT) begin
                        resume_d = phase_of(st_q);
                    end
                end else if (!rdy_n) begin
                    if (st_q == ST_RD_WAIT) begin
                        st_d     = ST_WR_ADS;
                        rd_cap_o = 1'b1;
                    end else if (st_q == ST_WR_WAIT) begin
                        st_d = ST_DONE;
                    end else begin
                        st_d      = ads_of(resume_q);
                        wb_pend_d = 1'b0;
                    end
                end
            end
            ST_BOFF: begin
                if (!boff_n) begin
                    if (snp_hitm && !wb_pend_q) begin
                        wb_pend_d = 1'b1;
                        wb_cap_o  = 1'b1;
                    end
                end else if (wb_pend_q) begin
                    st_d = ST_WB_ADS;
                end else begin
                    st_d = ads_of(resume_q);
                end
            end
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            resume_q  <= PH_RD;
            wb_pend_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            resume_q  <= resume_d;
            wb_pend_q <= wb_pend_d;
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/lkpair_hold.sv
// Holding registers for the locked pair.
// Keeps the accepted request for replay, the snooped modified line for the
// writeback, and the read result for the requester.
// Assumes the load strobes come from lkpair_ctrl and are mutually exclusive.
module lkpair_hold #(
    parameter int AW  = 32,
    parameter int DW  = 64,
    parameter int BEW = DW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           accept,
    input  logic           rd_cap,
    input  logic           wb_cap,
    input  logic [AW-1:0]  req_addr,
    input  logic [BEW-1:0] req_be,
    input  logic [DW-1:0]  req_wdata,
    input  logic [DW-1:0]  bus_din,
    input  logic [AW-1:0]  snp_addr,
    input  logic [DW-1:0]  snp_data,
    output logic [AW-1:0]  sv_addr,
    output logic [BEW-1:0] sv_be,
    output logic [DW-1:0]  sv_wdata,
    output logic [AW-1:0]  wb_addr,
    output logic [DW-1:0]  wb_data,
    output logic [DW-1:0]  rd_data
);

    // Request copy, loaded once per accepted pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv_addr  <= '0;
            sv_be    <= '0;
            sv_wdata <= '0;
        end else if (accept) begin
            sv_addr  <= req_addr;
            sv_be    <= req_be;
            sv_wdata <= req_wdata;
        end
    end

    // Modified line captured from the snoop during backoff.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_addr <= '0;
            wb_data <= '0;
        end else if (wb_cap) begin
            wb_addr <= snp_addr;
            wb_data <= snp_data;
        end
    end

    // Read data captured when the read half completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_cap) begin
            rd_data <= bus_din;
        end
    end

endmodule

// File: rtl/lkpair_drive.sv
// Bus output decode for the locked pair.
// Every output is a decode of the registered state, so the pins change one
// clock after the deciding edge. Values are parked at idle levels whenever
// the enables are low.
module lkpair_drive
    import lkpair_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 64,
    parameter int BEW = DW / 8
) (
    input  seq_state_e     state,
    input  logic [AW-1:0]  sv_addr,
    input  logic [BEW-1:0] sv_be,
    input  logic [DW-1:0]  sv_wdata,
    input  logic [AW-1:0]  wb_addr,
    input  logic [DW-1:0]  wb_data,
    output logic           busy,
    output logic           done,
    output logic           bus_oe,
    output logic           bus_dout_oe,
    output logic           bus_ads_n,
    output logic           bus_lock_n,
    output logic           bus_wr,
    output logic [AW-1:0]  bus_addr,
    output logic [BEW-1:0] bus_be,
    output logic [DW-1:0]  bus_dout
);

    // Decode pins from state and the holding registers.
    always_comb begin
        busy        = (state != ST_IDLE);
        done        = (state == ST_DONE);
        bus_oe      = 1'b0;
        bus_dout_oe = 1'b0;
        bus_ads_n   = 1'b1;
        bus_lock_n  = 1'b1;
        bus_wr      = 1'b0;
        bus_addr    = '0;
        bus_be      = '0;
        bus_dout    = '0;
        case (state)
            ST_RD_ADS, ST_RD_WAIT: begin
                bus_oe     = 1'b1;
                bus_lock_n = 1'b0;
                bus_ads_n  = (state != ST_RD_ADS);
                bus_addr   = sv_addr;
                bus_be     = sv_be;
            end
            ST_WR_ADS, ST_WR_WAIT: begin
                bus_oe      = 1'b1;
                bus_dout_oe = 1'b1;
                bus_lock_n  = 1'b0;
                bus_wr      = 1'b1;
                bus_ads_n   = (state != ST_WR_ADS);
                bus_addr    = sv_addr;
                bus_be      = sv_be;
                bus_dout    = sv_wdata;
            end
            ST_WB_ADS, ST_WB_WAIT: begin
                bus_oe      = 1'b1;
                bus_dout_oe = 1'b1;
                bus_lock_n  = 1'b0;
                bus_wr      = 1'b1;
                bus_ads_n   = (state != ST_WB_ADS);
                bus_addr    = wb_addr;
                bus_be      = '1;
                bus_dout    = wb_data;
            end
            default: begin
                bus_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lkpair_seq.sv
// Locked pair backoff sequencer, top level.
// Issues a locked read then write. Floats on backoff, writes back a snooped
// modified line under lock, and replays the aborted cycle on release.
// Assumes the system keeps the locked location unchanged while this block
// is backed off.
module lkpair_seq
    import lkpair_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 64,
    parameter int BEW = DW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [AW-1:0]  req_addr,
    input  logic [BEW-1:0] req_be,
    input  logic [DW-1:0]  req_wdata,
    output logic           busy,
    output logic           done,
    output logic [DW-1:0]  rdata,
    output logic           bus_oe,
    output logic           bus_dout_oe,
    output logic           bus_ads_n,
    output logic           bus_lock_n,
    output logic           bus_wr,
    output logic [AW-1:0]  bus_addr,
    output logic [BEW-1:0] bus_be,
    output logic [DW-1:0]  bus_dout,
    input  logic [DW-1:0]  bus_din,
    input  logic           bus_rdy_n,
    input  logic           bus_boff_n,
    input  logic           snp_hitm,
    input  logic [AW-1:0]  snp_addr,
    input  logic [DW-1:0]  snp_data
);

    seq_state_e     state;
    logic           accept, rd_cap, wb_cap;
    logic [AW-1:0]  sv_addr, wb_addr;
    logic [BEW-1:0] sv_be;
    logic [DW-1:0]  sv_wdata, wb_data;

    lkpair_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .boff_n   (bus_boff_n),
        .rdy_n    (bus_rdy_n),
        .snp_hitm (snp_hitm),
        .state_o  (state),
        .accept_o (accept),
        .rd_cap_o (rd_cap),
        .wb_cap_o (wb_cap)
    );

    lkpair_hold #(.AW(AW), .DW(DW), .BEW(BEW)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .rd_cap   (rd_cap),
        .wb_cap   (wb_cap),
        .req_addr (req_addr),
        .req_be   (req_be),
        .req_wdata(req_wdata),
        .bus_din  (bus_din),
        .snp_addr (snp_addr),
        .snp_data (snp_data),
        .sv_addr  (sv_addr),
        .sv_be    (sv_be),
        .sv_wdata (sv_wdata),
        .wb_addr  (wb_addr),
        .wb_data  (wb_data),
        .rd_data  (rdata)
    );

    lkpair_drive #(.AW(AW), .DW(DW), .BEW(BEW)) u_drive (
        .state      (state),
        .sv_addr    (sv_addr),
        .sv_be      (sv_be),
        .sv_wdata   (sv_wdata),
        .wb_addr    (wb_addr),
        .wb_data    (wb_data),
        .busy       (busy),
        .done       (done),
        .bus_oe     (bus_oe),
        .bus_dout_oe(bus_dout_oe),
        .bus_ads_n  (bus_ads_n),
        .bus_lock_n (bus_lock_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_be     (bus_be),
        .bus_dout   (bus_dout)
    );

endmodule

// File: rtl/lkpair_chk.sv
// Protocol checker for lkpair_seq, attached by bind; observes ports only.
module lkpair_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_boff_n,
    input logic busy,
    input logic done,
    input logic bus_oe,
    input logic bus_dout_oe,
    input logic bus_ads_n,
    input logic bus_lock_n,
    input logic bus_wr
);

    // R2: strobe lasts one clock
    p_ads_one_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ads_n |=> bus_ads_n);

    // R2: strobe only while driving with lock held
    p_ads_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ads_n |-> (!bus_lock_n && bus_oe));

    // R3: write data enabled only in a driven write
    p_dout_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dout_oe |-> (bus_wr && bus_oe));

    // R4: done is a single-clock pulse with lock released
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_unlocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_lock_n && !bus_oe));

    // R5: backoff at an edge floats the bus in the next clock
    p_float_after_boff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_boff_n |=> (!bus_oe && !bus_dout_oe));

    // R8: no acceptance while idle under backoff
    p_idle_boff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !bus_boff_n) |=> !busy);

endmodule

bind lkpair_seq lkpair_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_boff_n (bus_boff_n),
    .busy       (busy),
    .done       (done),
    .bus_oe     (bus_oe),
    .bus_dout_oe(bus_dout_oe),
    .bus_ads_n  (bus_ads_n),
    .bus_lock_n (bus_lock_n),
    .bus_wr     (bus_wr)
);

// File: tb/lkpair_seq_bench.sv
// Self-checking bench for lkpair_seq: table-driven clean pairs, then
// directed backoff, snoop writeback and acceptance cases.
module lkpair_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 4;
    localparam logic [31:0] V_ADDR [NV] = '{32'h0000_1000, 32'h0000_2040, 32'hFFFF_FFF8, 32'h1234_5670};
    localparam logic [7:0]  V_BE   [NV] = '{8'hFF, 8'h0F, 8'hF0, 8'h81};
    localparam logic [63:0] V_WD   [NV] = '{64'h1111_2222_3333_4444, 64'hDEAD_BEEF_0000_0001,
                                            64'h0, 64'hFFFF_FFFF_FFFF_FFFF};
    localparam logic [63:0] V_RD   [NV] = '{64'hA5A5_A5A5_5A5A_5A5A, 64'h0123_4567_89AB_CDEF,
                                            64'hFFFF_0000_FFFF_0000, 64'h0};
    localparam int V_RW [NV] = '{0, 2, 1, 3};
    localparam int V_WW [NV] = '{0, 1, 3, 2};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [7:0]  req_be;
    logic [63:0] req_wdata;
    logic        busy, done;
    logic [63:0] rdata;
    logic        bus_oe, bus_dout_oe, bus_ads_n, bus_lock_n, bus_wr;
    logic [31:0] bus_addr;
    logic [7:0]  bus_be;
    logic [63:0] bus_dout;
    logic [63:0] bus_din;
    logic        bus_rdy_n, bus_boff_n, snp_hitm;
    logic [31:0] snp_addr;
    logic [63:0] snp_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    lkpair_seq u_lkpair_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata),
        .bus_oe(bus_oe), .bus_dout_oe(bus_dout_oe), .bus_ads_n(bus_ads_n),
        .bus_lock_n(bus_lock_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_dout(bus_dout), .bus_din(bus_din),
        .bus_rdy_n(bus_rdy_n), .bus_boff_n(bus_boff_n),
        .snp_hitm(snp_hitm), .snp_addr(snp_addr), .snp_data(snp_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: a hung run counts as one miscompare.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad + 1);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One rising edge, then settle at the falling edge.
    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Present a request for one edge; returns in the read address clock.
    task automatic start_pair(input logic [31:0] a, input logic [7:0] be, input logic [63:0] wd);
        req_valid = 1'b1; req_addr = a; req_be = be; req_wdata = wd;
        tick;
        req_valid = 1'b0;
    endtask

    // From the write address clock: complete the write and check done.
    task automatic finish_write(input logic [63:0] exp_rd);
        tick;
        bus_rdy_n = 1'b0;
        tick;
        bus_rdy_n = 1'b1;
        chk("R4 done", done, 1);
        chk("R4 lock released", bus_lock_n, 1);
        chk("R4 rdata", rdata, exp_rd);
        tick;
        chk("R4 done single", done, 0);
        chk("R4 idle busy", busy, 0);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_be = '0; req_wdata = '0;
        bus_din = '0; bus_rdy_n = 1'b1; bus_boff_n = 1'b1;
        snp_hitm = 1'b0; snp_addr = '0; snp_data = '0;
        @(negedge clk);
        tick; tick;
        // R1: reset state
        chk("R1 oe", bus_oe, 0);
        chk("R1 dout_oe", bus_dout_oe, 0);
        chk("R1 ads_n", bus_ads_n, 1);
        chk("R1 lock_n", bus_lock_n, 1);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        rst_n = 1'b1;
        tick;
        chk("R1 after release busy", busy, 0);

        // Table walk: clean locked pairs with varied wait states.
        for (int i = 0; i < NV; i++) begin
            start_pair(V_ADDR[i], V_BE[i], V_WD[i]);
            chk("R2 ads", bus_ads_n, 0);
            chk("R2 lock", bus_lock_n, 0);
            chk("R2 read", bus_wr, 0);
            chk("R2 oe", bus_oe, 1);
            chk("R2 addr", bus_addr, V_ADDR[i]);
            chk("R2 be", bus_be, V_BE[i]);
            tick;
            chk("R2 ads one clock", bus_ads_n, 1);
            for (int w = 0; w < V_RW[i]; w++) tick;
            bus_rdy_n = 1'b0; bus_din = V_RD[i];
            tick;
            bus_rdy_n = 1'b1; bus_din = '0;
            chk("R3 write ads", bus_ads_n, 0);
            chk("R3 lock held", bus_lock_n, 0);
            chk("R3 write", bus_wr, 1);
            chk("R3 wdata", bus_dout, V_WD[i]);
            chk("R3 dout_oe", bus_dout_oe, 1);
            tick;
            chk("R3 lock in write wait", bus_lock_n, 0);
            for (int w = 0; w < V_WW[i]; w++) tick;
            bus_rdy_n = 1'b0;
            tick;
            bus_rdy_n = 1'b1;
            chk("R4 done", done, 1);
            chk("R4 lock released", bus_lock_n, 1);
            chk("R4 oe", bus_oe, 0);
            chk("R4 rdata", rdata, V_RD[i]);
            tick;
            chk("R4 done single", done, 0);
            chk("R4 busy clear", busy, 0);
        end

        // R5/R6/R9: backoff during read wait with ready at the same edge.
        start_pair(32'hCAFE_0000, 8'h3C, 64'h5555_6666_7777_8888);
        tick;
        bus_boff_n = 1'b0; bus_rdy_n = 1'b0; bus_din = 64'hBAD0_BAD0_BAD0_BAD0;
        tick;
        bus_rdy_n = 1'b1;
        chk("R5 oe floated", bus_oe, 0);
        chk("R5 dout floated", bus_dout_oe, 0);
        req_valid = 1'b1; req_addr = 32'h0BAD_0BAD; req_wdata = 64'h0;
        tick;
        chk("R5 still floated", bus_oe, 0);
        tick;
        chk("R5 still floated 2", bus_oe, 0);
        bus_boff_n = 1'b1;
        tick;
        req_valid = 1'b0;
        chk("R6 restart ads", bus_ads_n, 0);
        chk("R6 restart read", bus_wr, 0);
        chk("R6 restart lock", bus_lock_n, 0);
        chk("R9 addr kept", bus_addr, 32'hCAFE_0000);
        chk("R6 be kept", bus_be, 8'h3C);
        tick;
        bus_rdy_n = 1'b0; bus_din = 64'h0F0F_0F0F_0F0F_0F0F;
        tick;
        bus_rdy_n = 1'b1;
        chk("R9 wdata kept", bus_dout, 64'h5555_6666_7777_8888);
        finish_write(64'h0F0F_0F0F_0F0F_0F0F);

        // R7/R6: backoff in write address clock, snoop hit, writeback then replay.
        start_pair(32'h0000_8000, 8'hFF, 64'hAAAA_BBBB_CCCC_DDDD);
        tick;
        bus_rdy_n = 1'b0; bus_din = 64'h1357_9BDF_2468_ACE0;
        tick;
        bus_rdy_n = 1'b1; bus_boff_n = 1'b0;
        tick;
        chk("R5 write aborted", bus_oe, 0);
        snp_hitm = 1'b1; snp_addr = 32'h0000_4400; snp_data = 64'h7777_0000_7777_0000;
        tick;
        snp_hitm = 1'b0; snp_addr = 32'hFFFF_0000; snp_data = '1; bus_boff_n = 1'b1;
        tick;
        chk("R7 wb ads", bus_ads_n, 0);
        chk("R7 wb lock", bus_lock_n, 0);
        chk("R7 wb write", bus_wr, 1);
        chk("R7 wb addr", bus_addr, 32'h0000_4400);
        chk("R7 wb be", bus_be, 8'hFF);
        chk("R7 wb data", bus_dout, 64'h7777_0000_7777_0000);
        tick;
        chk("R7 wb lock wait", bus_lock_n, 0);
        bus_rdy_n = 1'b0;
        tick;
        bus_rdy_n = 1'b1;
        chk("R6 replay ads", bus_ads_n, 0);
        chk("R6 replay is write", bus_wr, 1);
        chk("R6 replay addr", bus_addr, 32'h0000_8000);
        chk("R6 replay data", bus_dout, 64'hAAAA_BBBB_CCCC_DDDD);
        chk("R7 replay lock", bus_lock_n, 0);
        finish_write(64'h1357_9BDF_2468_ACE0);

        // R10: backoff aborts the writeback itself.
        start_pair(32'h0000_9000, 8'h0F, 64'h9999_8888_7777_6666);
        tick;
        bus_boff_n = 1'b0;
        tick;
        snp_hitm = 1'b1; snp_addr = 32'h0000_5500; snp_data = 64'h4444_3333_2222_1111;
        tick;
        snp_hitm = 1'b0; bus_boff_n = 1'b1;
        tick;
        chk("R10 first wb addr", bus_addr, 32'h0000_5500);
        tick;
        bus_boff_n = 1'b0;
        tick;
        chk("R10 wb floated", bus_oe, 0);
        bus_boff_n = 1'b1;
        tick;
        chk("R10 wb reissued ads", bus_ads_n, 0);
        chk("R10 wb reissued addr", bus_addr, 32'h0000_5500);
        chk("R10 wb reissued write", bus_wr, 1);
        tick;
        bus_rdy_n = 1'b0;
        tick;
        bus_rdy_n = 1'b1;
        chk("R10 read resumes", bus_wr, 0);
        chk("R10 read addr", bus_addr, 32'h0000_9000);
        chk("R10 read ads", bus_ads_n, 0);
        tick;
        bus_rdy_n = 1'b0; bus_din = 64'hC0DE_C0DE_C0DE_C0DE;
        tick;
        bus_rdy_n = 1'b1;
        chk("R10 write data", bus_dout, 64'h9999_8888_7777_6666);
        finish_write(64'hC0DE_C0DE_C0DE_C0DE);

        // R8: backoff while idle blocks acceptance.
        bus_boff_n = 1'b0; req_valid = 1'b1; req_addr = 32'h0000_A000;
        req_be = 8'h01; req_wdata = 64'h1;
        tick;
        chk("R8 not accepted", busy, 0);
        chk("R8 floated", bus_oe, 0);
        tick;
        chk("R8 still idle", busy, 0);
        bus_boff_n = 1'b1;
        tick;
        req_valid = 1'b0;
        chk("R8 accepted after release", busy, 1);
        chk("R8 addr", bus_addr, 32'h0000_A000);
        tick;
        bus_rdy_n = 1'b0; bus_din = 64'h2;
        tick;
        bus_rdy_n = 1'b1;
        finish_write(64'h2);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule